// File: doc/BRIEF.md
# Power-up reset sequencer

This block keeps a processor core in reset after a power-on event, a brown-out, or an assertion of the external active-low reset pin. It then lets the core go through a chain of timed stages. The first stage is a power-up delay counted on a slow free-running RC clock. The second is an oscillator start-up count that runs on the main oscillator clock itself. The third is a wait for the filtered reset pin to be released.

The supply monitor is a synchronized digital flag, and each dip on it is filtered in RC ticks. A dip that lasts long enough forces a brown-out reset. After the supply recovers, the full power-up delay runs again. If the supply dips while that delay is running, the brown-out sequence starts over.

The oscillator start-up count runs only in the crystal-type oscillator modes. It is triggered by power-on and by a wake-from-sleep request. A wake does not reset the core. It raises a hold output instead. The start request and the done indication cross between the two clock domains through two-flop synchronizers on a four-phase level handshake.

Two sticky flags record the cause of the last reset, and a write strobe clears them.

Top module: `pwrup_rst_ctrl`

## Requirements
- R1: While porPulse is high, coreReset=1, porFlag=1, borFlag=1 and wakeHold=0.
- R2: With cfgPwrtEn=1, the core stays in reset for at least PWRT_TICKS rcClk ticks after porPulse falls. In RC mode (cfgOscMode=3) with the pin high, it is released within PWRT_TICKS+3 ticks.
- R3: With cfgBorEn=1, the power-up delay is used even when cfgPwrtEn=0.
- R4: In the crystal modes (cfgOscMode 0, 1 or 2), a power-on runs OST_CYCLES oscClk cycles after the power-up delay, and reset is released only after that count. In mode 3 the count is skipped.
- R5: With both cfgPwrtEn=0 and cfgBorEn=0 in mode 3, release waits only for the pin filter. It comes within PIN_SAMPLES+5 ticks.
- R6: With cfgBorEn=1 and the core running, supplyOk low on BOR_TICKS consecutive ticks is ignored. Low on BOR_TICKS+1 ticks asserts coreReset and sets borFlag.
- R7: A brown-out reset lasts while supplyOk=0. Once supplyOk returns to 1, a full PWRT_TICKS delay runs and the oscillator count is skipped, in any mode.
- R8: With cfgBorEn=1, supplyOk=0 during the power-up delay restarts the brown-out sequence. The delay then runs in full from the next return of supplyOk.
- R9: A low pulse on mclrN seen on fewer than PIN_SAMPLES synchronized samples is ignored. A longer low resets the core. The core is released within PIN_SAMPLES+4 ticks of the pin going high, and internal delays do not rerun.
- R10: If mclrN is held low past every internal delay after power-on, the core is released within PIN_SAMPLES+4 ticks of the pin going high.
- R11: Power-on sets both porFlag and borFlag. A brown-out sets only borFlag. statusClr=1 clears both. A pin reset changes neither.
- R12: In a crystal mode, a wakeReq pulse while the core runs raises wakeHold for the oscillator count, and coreReset stays 0. In mode 3 a wakeReq has no effect on wakeHold.
- R13: With cfgBorEn=0, supply dips of any length leave a running core out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rcClk | input | 1 | Slow RC clock; each rising edge is one tick |
| oscClk | input | 1 | Main oscillator clock |
| porPulse | input | 1 | Power-on pulse, active high, asynchronous |
| supplyOk | input | 1 | Synchronized supply-above-threshold flag |
| mclrN | input | 1 | External reset pin, active low, asynchronous |
| cfgPwrtEn | input | 1 | Power-up delay enable |
| cfgBorEn | input | 1 | Brown-out detection enable |
| cfgOscMode | input | 2 | 0 low-power crystal, 1 crystal, 2 high-speed crystal, 3 RC |
| wakeReq | input | 1 | Wake-from-sleep request pulse |
| statusClr | input | 1 | Clears both cause flags |
| coreReset | output | 1 | Core reset, active high |
| porFlag | output | 1 | Sticky power-on cause flag |
| borFlag | output | 1 | Sticky brown-out cause flag |
| wakeHold | output | 1 | Core hold during the wake oscillator count |

## Verification
The bench builds the block with PWRT_TICKS=20, OST_CYCLES=16, BOR_TICKS=4 and PIN_SAMPLES=3. It runs rcClk and oscClk at unrelated periods of 4 ns and 6 ns.

These small values make it cheap to sweep every combination of the two enables and the four oscillator modes at power-on. For each combination, the bench computes a lower and an upper bound on the release time.

They also put the exact filter edges within reach: a dip of BOR_TICKS versus BOR_TICKS+1 ticks, and a pin pulse just short of PIN_SAMPLES. The same goes for a dip inside the restarted delay and wake holds in both crystal and RC modes.

// File: rtl/pwrup_rst_pkg.sv
`timescale 1ns/1ps
package pwrup_rst_pkg;

  typedef enum logic [1:0] {
    OSC_LP = 2'd0,
    OSC_XT = 2'd1,
    OSC_HS = 2'd2,
    OSC_RC = 2'd3
  } oscMode_e;

  typedef enum logic [2:0] {
    ST_PWRT  = 3'd0,
    ST_OST   = 3'd1,
    ST_READY = 3'd2,
    ST_RUN   = 3'd3,
    ST_WAKE  = 3'd4,
    ST_BOR   = 3'd5
  } seqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic pwrtRun;
    logic bfArm;
    logic ostReq;
  } ctlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic pwrtDone;
    logic bfTrip;
    logic ostAck;
    logic pinLevel;
  } dpStatus_t;

  function automatic logic isCrystal(input logic [1:0] mode);
    return mode != OSC_RC;
  endfunction

endpackage

// File: rtl/pwrup_sync2.sv
`timescale 1ns/1ps
module pwrup_sync2 #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwrup_rst_dp.sv
`timescale 1ns/1ps
module pwrup_rst_dp
  import pwrup_rst_pkg::*;
#(
  parameter int PWRT_TICKS  = 2250,
  parameter int OST_CYCLES  = 1024,
  parameter int BOR_TICKS   = 3,
  parameter int PIN_SAMPLES = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       rcClk,
  input  logic       oscClk,
  input  logic       porPulse,
  input  logic       supplyOk,
  input  logic       mclrN,
  input  ctlStrobe_t strobe,
  output dpStatus_t  status
);
  localparam int PWRT_W = $clog2(PWRT_TICKS + 1);
  localparam int OST_W  = $clog2(OST_CYCLES + 1);
  localparam int BF_W   = $clog2(BOR_TICKS + 1);
  localparam int PIN_W  = $clog2(PIN_SAMPLES + 1);
  localparam logic [PWRT_W-1:0] PWRT_LAST = PWRT_W'(PWRT_TICKS - 1);
  localparam logic [OST_W-1:0]  OST_LAST  = OST_W'(OST_CYCLES - 1);
  localparam logic [BF_W-1:0]   BF_MAX    = BF_W'(BOR_TICKS);
  localparam logic [PIN_W-1:0]  PIN_LAST  = PIN_W'(PIN_SAMPLES - 1);

  // ---------------- reset pin glitch filter ----------------
  logic             pinSyncd;
  logic [PIN_W-1:0] pinCnt;
  logic             pinLevel;

  pwrup_sync2 #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pinSync (
    .clk(rcClk), .rst(porPulse), .d(mclrN), .q(pinSyncd)
  );

  always_ff @(posedge rcClk or posedge porPulse) begin
    if (porPulse) begin
      pinCnt   <= '0;
      pinLevel <= 1'b0;
    end else if (pinSyncd == pinLevel) begin
      pinCnt <= '0;
    end else if (pinCnt == PIN_LAST) begin
      pinLevel <= pinSyncd;
      pinCnt   <= '0;
    end else begin
      pinCnt <= pinCnt + 1'b1;
    end
  end

  p_pin_settled_r9: assert property (@(posedge rcClk) disable iff (porPulse)
    !$stable(pinLevel) |-> ($past(pinSyncd) == pinLevel));

  // ---------------- brown-out dip filter ----------------
  logic [BF_W-1:0] bfCnt;
  logic            bfTrip;

  always_ff @(posedge rcClk or posedge porPulse) begin
    if (porPulse)                       bfCnt <= '0;
    else if (!strobe.bfArm || supplyOk) bfCnt <= '0;
    else if (bfCnt != BF_MAX)           bfCnt <= bfCnt + 1'b1;
  end

  assign bfTrip = strobe.bfArm && !supplyOk && (bfCnt == BF_MAX);

  p_trip_after_low_r6: assert property (@(posedge rcClk) disable iff (porPulse)
    bfTrip |-> $past(!supplyOk));

  // ---------------- power-up delay ----------------
  logic [PWRT_W-1:0] pwrtCnt;
  logic              pwrtDone;

  assign pwrtDone = strobe.pwrtRun && (pwrtCnt == PWRT_LAST);

  always_ff @(posedge rcClk or posedge porPulse) begin
    if (porPulse)            pwrtCnt <= '0;
    else if (!strobe.pwrtRun) pwrtCnt <= '0;
    else if (!pwrtDone)      pwrtCnt <= pwrtCnt + 1'b1;
  end

  // ---------------- oscillator-domain start-up count ----------------
  logic             oscRst;
  logic             reqSync;
  logic [OST_W-1:0] ostCnt;
  logic             ackOsc;
  logic             ackSync;

  pwrup_sync2 #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_oscRstSync (
    .clk(oscClk), .rst(porPulse), .d(1'b0), .q(oscRst)
  );

  pwrup_sync2 #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_reqSync (
    .clk(oscClk), .rst(oscRst), .d(strobe.ostReq), .q(reqSync)
  );

  always_ff @(posedge oscClk or posedge oscRst) begin
    if (oscRst) begin
      ostCnt <= '0;
      ackOsc <= 1'b0;
    end else if (!reqSync) begin
      ostCnt <= '0;
      ackOsc <= 1'b0;
    end else if (ostCnt == OST_LAST) begin
      ackOsc <= 1'b1;
    end else begin
      ostCnt <= ostCnt + 1'b1;
    end
  end

  p_ack_after_req_r4: assert property (@(posedge oscClk) disable iff (oscRst)
    $rose(ackOsc) |-> reqSync);

  pwrup_sync2 #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ackSync (
    .clk(rcClk), .rst(porPulse), .d(ackOsc), .q(ackSync)
  );

  assign status.pwrtDone = pwrtDone;
  assign status.bfTrip   = bfTrip;
  assign status.ostAck   = ackSync;
  assign status.pinLevel = pinLevel;

endmodule

// File: rtl/pwrup_rst_ctl.sv
`timescale 1ns/1ps
module pwrup_rst_ctl
  import pwrup_rst_pkg::*;
(
  input  logic       rcClk,
  input  logic       porPulse,
  input  logic       supplyOk,
  input  logic       cfgPwrtEn,
  input  logic       cfgBorEn,
  input  logic [1:0] cfgOscMode,
  input  logic       wakeReq,
  input  logic       statusClr,
  input  dpStatus_t  dpStat,
  output ctlStrobe_t strobe,
  output logic       coreReset,
  output logic       porFlag,
  output logic       borFlag,
  output logic       wakeHold
);
  seqState_e state, nextState;
  logic      fromPor;
  logic      ostReqQ;
  logic      usePwrt;
  logic      xtal;
  logic      enterBor;

  assign usePwrt = cfgPwrtEn || cfgBorEn;
  assign xtal    = isCrystal(cfgOscMode);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_PWRT: begin
        if (cfgBorEn && !supplyOk)             nextState = ST_BOR;
        else if (!usePwrt || dpStat.pwrtDone)  nextState = (xtal && fromPor) ? ST_OST : ST_READY;
      end
      ST_OST: begin
        if (dpStat.bfTrip)       nextState = ST_BOR;
        else if (dpStat.ostAck)  nextState = ST_READY;
      end
      ST_READY: begin
        if (dpStat.bfTrip)         nextState = ST_BOR;
        else if (dpStat.pinLevel)  nextState = ST_RUN;
      end
      ST_RUN: begin
        if (dpStat.bfTrip)                           nextState = ST_BOR;
        else if (!dpStat.pinLevel)                   nextState = ST_READY;
        else if (wakeReq && xtal && !dpStat.ostAck)  nextState = ST_WAKE;
      end
      ST_WAKE: begin
        if (dpStat.bfTrip)          nextState = ST_BOR;
        else if (!dpStat.pinLevel)  nextState = ST_READY;
        else if (dpStat.ostAck)     nextState = ST_RUN;
      end
      ST_BOR: begin
        if (supplyOk) nextState = ST_PWRT;
      end
      default: nextState = ST_BOR;
    endcase
  end

  assign enterBor = (nextState == ST_BOR) && (state != ST_BOR);

  always_ff @(posedge rcClk or posedge porPulse) begin
    if (porPulse) begin
      state   <= ST_PWRT;
      fromPor <= 1'b1;
      ostReqQ <= 1'b0;
    end else begin
      state   <= nextState;
      ostReqQ <= (nextState == ST_OST) || (nextState == ST_WAKE);
      if (state == ST_BOR) fromPor <= 1'b0;
    end
  end

  always_ff @(posedge rcClk or posedge porPulse) begin
    if (porPulse) begin
      porFlag <= 1'b1;
      borFlag <= 1'b1;
    end else begin
      if (statusClr) begin
        porFlag <= 1'b0;
        borFlag <= 1'b0;
      end
      if (enterBor) borFlag <= 1'b1;
    end
  end

  assign strobe.pwrtRun = (state == ST_PWRT) && usePwrt;
  assign strobe.bfArm   = cfgBorEn && (state inside {ST_OST, ST_READY, ST_RUN, ST_WAKE});
  assign strobe.ostReq  = ostReqQ;

  assign coreReset = !((state == ST_RUN) || (state == ST_WAKE));
  assign wakeHold  = (state == ST_WAKE);

  p_release_pin_high_r9: assert property (@(posedge rcClk) disable iff (porPulse)
    $fell(coreReset) |-> $past(dpStat.pinLevel));

  p_bor_flag_reset_r6: assert property (@(posedge rcClk) disable iff (porPulse)
    $rose(borFlag) |-> coreReset);

  p_wake_xtal_r12: assert property (@(posedge rcClk) disable iff (porPulse)
    $rose(wakeHold) |-> $past(cfgOscMode != OSC_RC));

  p_dip_restart_r8: assert property (@(posedge rcClk) disable iff (porPulse)
    (state == ST_PWRT && cfgBorEn && !supplyOk) |=> (state == ST_BOR));

endmodule

// File: rtl/pwrup_rst_ctrl.sv
`timescale 1ns/1ps
module pwrup_rst_ctrl
  import pwrup_rst_pkg::*;
#(
  parameter int PWRT_TICKS  = 2250,
  parameter int OST_CYCLES  = 1024,
  parameter int BOR_TICKS   = 3,
  parameter int PIN_SAMPLES = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       rcClk,
  input  logic       oscClk,
  input  logic       porPulse,
  input  logic       supplyOk,
  input  logic       mclrN,
  input  logic       cfgPwrtEn,
  input  logic       cfgBorEn,
  input  logic [1:0] cfgOscMode,
  input  logic       wakeReq,
  input  logic       statusClr,
  output logic       coreReset,
  output logic       porFlag,
  output logic       borFlag,
  output logic       wakeHold
);
  ctlStrobe_t strobe;
  dpStatus_t  dpStat;

  pwrup_rst_ctl u_ctl (
    .rcClk(rcClk), .porPulse(porPulse), .supplyOk(supplyOk),
    .cfgPwrtEn(cfgPwrtEn), .cfgBorEn(cfgBorEn), .cfgOscMode(cfgOscMode),
    .wakeReq(wakeReq), .statusClr(statusClr), .dpStat(dpStat),
    .strobe(strobe), .coreReset(coreReset), .porFlag(porFlag),
    .borFlag(borFlag), .wakeHold(wakeHold)
  );

  pwrup_rst_dp #(
    .PWRT_TICKS(PWRT_TICKS), .OST_CYCLES(OST_CYCLES), .BOR_TICKS(BOR_TICKS),
    .PIN_SAMPLES(PIN_SAMPLES), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .rcClk(rcClk), .oscClk(oscClk), .porPulse(porPulse), .supplyOk(supplyOk),
    .mclrN(mclrN), .strobe(strobe), .status(dpStat)
  );
endmodule

// File: tb/pwrup_rst_ctrl_bench.sv
`timescale 1ns/1ps
module pwrup_rst_ctrl_bench;
  localparam int P  = 20;
  localparam int OC = 16;
  localparam int BT = 4;
  localparam int PS = 3;

  logic rcClk = 1'b0, oscClk = 1'b0;
  logic porPulse = 1'b1, supplyOk = 1'b1, mclrN = 1'b1;
  logic cfgPwrtEn = 1'b1, cfgBorEn = 1'b0;
  logic [1:0] cfgOscMode = 2'd3;
  logic wakeReq = 1'b0, statusClr = 1'b0;
  logic coreReset, porFlag, borFlag, wakeHold;
  int nChecks = 0, nFail = 0;

  always #2 rcClk = ~rcClk;
  always #3 oscClk = ~oscClk;

  pwrup_rst_ctrl #(.PWRT_TICKS(P), .OST_CYCLES(OC), .BOR_TICKS(BT), .PIN_SAMPLES(PS)) u_pwrup_rst_ctrl (
    .rcClk(rcClk), .oscClk(oscClk), .porPulse(porPulse), .supplyOk(supplyOk), .mclrN(mclrN),
    .cfgPwrtEn(cfgPwrtEn), .cfgBorEn(cfgBorEn), .cfgOscMode(cfgOscMode), .wakeReq(wakeReq),
    .statusClr(statusClr), .coreReset(coreReset), .porFlag(porFlag), .borFlag(borFlag),
    .wakeHold(wakeHold)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic powerUp(input logic pw, input logic bo, input logic [1:0] md);
    @(negedge rcClk);
    cfgPwrtEn = pw; cfgBorEn = bo; cfgOscMode = md; porPulse = 1'b1;
    repeat (3) @(negedge rcClk);
    porPulse = 1'b0;
  endtask

  // counts edges from now; reset must be held at edge heldAt, released by relBy
  task automatic window(input string tag, input int heldAt, input int relBy);
    for (int i = 1; i <= relBy; i++) begin
      @(posedge rcClk); #1;
      if (i == heldAt) chk(tag, "held", int'(coreReset), 1);
    end
    chk(tag, "released", int'(coreReset), 0);
  endtask

  task automatic clearFlags();
    @(negedge rcClk); statusClr = 1'b1;
    @(negedge rcClk); statusClr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge rcClk);
    nFail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge rcClk); #1;
    chk("R1", "coreReset", int'(coreReset), 1);
    chk("R1", "porFlag", int'(porFlag), 1);
    chk("R1", "borFlag", int'(borFlag), 1);
    chk("R1", "wakeHold", int'(wakeHold), 0);

    // sweep enables and oscillator modes at power-on
    for (int pw = 0; pw < 2; pw++) begin
      for (int bo = 0; bo < 2; bo++) begin
        for (int md = 0; md < 4; md++) begin
          int base, heldAt, relBy;
          string tag;
          logic xt;
          xt   = (md != 3);
          base = (pw != 0 || bo != 0) ? P : 1;
          if (xt) begin
            heldAt = base + (OC * 6) / 4; relBy = base + 45; tag = "R4";
          end else if (pw != 0 || bo != 0) begin
            heldAt = P; relBy = P + 3; tag = (pw != 0) ? "R2" : "R3";
          end else begin
            heldAt = PS + 1; relBy = PS + 5; tag = "R5";
          end
          powerUp(pw[0], bo[0], md[1:0]);
          window(tag, heldAt, relBy);
          chk("R11", "porFlag after power-on", int'(porFlag), 1);
          chk("R11", "borFlag after power-on", int'(borFlag), 1);
        end
      end
    end

    // brown-out, crystal mode
    powerUp(1'b0, 1'b1, 2'd0);
    window("R4", 1, 80);
    clearFlags();
    #1 chk("R11", "flags cleared", int'({porFlag, borFlag}), 0);

    @(negedge rcClk); supplyOk = 1'b0;
    repeat (BT) @(negedge rcClk);
    supplyOk = 1'b1;
    repeat (6) @(posedge rcClk); #1;
    chk("R6", "short dip coreReset", int'(coreReset), 0);
    chk("R6", "short dip borFlag", int'(borFlag), 0);

    @(negedge rcClk); supplyOk = 1'b0;
    repeat (20) @(negedge rcClk);
    chk("R6", "long dip coreReset", int'(coreReset), 1);
    chk("R6", "long dip borFlag", int'(borFlag), 1);
    chk("R11", "brown-out leaves porFlag", int'(porFlag), 0);
    repeat (10) @(negedge rcClk);
    chk("R7", "held while low", int'(coreReset), 1);
    supplyOk = 1'b1;
    window("R7", P, P + 4);

    // R8: dip during the delay restarts it
    @(negedge rcClk); supplyOk = 1'b0;
    repeat (20) @(negedge rcClk);
    supplyOk = 1'b1;
    repeat (10) @(negedge rcClk);
    supplyOk = 1'b0;
    repeat (2) @(negedge rcClk);
    supplyOk = 1'b1;
    window("R8", P, P + 4);

    // R13: brown-out disabled
    @(negedge rcClk); cfgBorEn = 1'b0; supplyOk = 1'b0;
    repeat (20) @(negedge rcClk);
    chk("R13", "dip ignored", int'(coreReset), 0);
    supplyOk = 1'b1;

    // R9: pin glitch and pin reset
    clearFlags();
    @(negedge rcClk); mclrN = 1'b0;
    repeat (PS - 1) @(negedge rcClk);
    mclrN = 1'b1;
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 10; i++) begin
        @(posedge rcClk); #1;
        if (coreReset) seen++;
      end
      chk("R9", "glitch ignored", seen, 0);
    end
    @(negedge rcClk); mclrN = 1'b0;
    repeat (10) @(negedge rcClk);
    chk("R9", "pin reset", int'(coreReset), 1);
    chk("R11", "pin reset flags", int'({porFlag, borFlag}), 0);
    mclrN = 1'b1;
    window("R9", PS + 1, PS + 4);

    // R10: pin held low through power-up
    @(negedge rcClk); mclrN = 1'b0;
    powerUp(1'b1, 1'b0, 2'd0);
    repeat (100) @(negedge rcClk);
    chk("R10", "held by pin", int'(coreReset), 1);
    mclrN = 1'b1;
    window("R10", PS + 1, PS + 4);

    // R12: wake in crystal mode
    @(negedge rcClk); wakeReq = 1'b1;
    @(negedge rcClk); wakeReq = 1'b0;
    repeat (2) @(posedge rcClk); #1;
    chk("R12", "wakeHold raised", int'(wakeHold), 1);
    chk("R12", "core runs during wake", int'(coreReset), 0);
    repeat (17) @(posedge rcClk); #1;
    chk("R12", "wakeHold still up", int'(wakeHold), 1);
    repeat (41) @(posedge rcClk); #1;
    chk("R12", "wakeHold dropped", int'(wakeHold), 0);
    chk("R12", "core still running", int'(coreReset), 0);

    // R12: wake in RC mode has no effect
    repeat (20) @(negedge rcClk);
    cfgOscMode = 2'd3; wakeReq = 1'b1;
    @(negedge rcClk); wakeReq = 1'b0;
    repeat (3) @(posedge rcClk); #1;
    chk("R12", "RC mode wake ignored", int'(wakeHold), 0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule